// File: doc/BRIEF.md
# Programmable Serial Delay Line

This block delays a one-bit serial stream by a number of clocks chosen at run time. A long chain of flip-flops with a wide output selector would grow in both area and logic depth as the maximum delay grows. Here a one-bit-wide memory keeps the recent bit history as a circular buffer instead. Each enabled clock the incoming bit goes into the slot named by a free-running write pointer. The output is fetched from a slot that trails the write pointer by the programmed length, and both addresses wrap at the buffer size.

The buffer holds 2^ADDR_W bits, so lengths run from 1 to 2^ADDR_W - 1. The default of 12 address bits covers delays beyond 3454 clocks, and a width of 14 gives the full 16K range. A clock enable freezes the whole line. The length input may change on any cycle and takes effect at once, with no flush. The stored history has no reset. It starts as all zeros, so slots that have never been written read as 0.

Top module: `prog_delay_line`

## Requirements
- R1: For a length N with 2 <= N <= 2^ADDR_W - 1 held steady, the output after enabled clock edge t+N equals the input sampled at enabled edge t.
- R2: With N = 1 the line behaves as a single flip-flop: the output after an enabled edge equals the input sampled at the enabled edge before it.
- R3: A length of 0 is illegal and gives exactly the behaviour of N = 1.
- R4: While the clock enable is low, the write pointer does not move, no slot is written and the output holds its value. Edges with the enable low are not counted as edges in R1, R2, R5 and R7.
- R5: The output after enabled edge j equals the input from enabled edge j - N, where N is the length applied at enabled edge j-1. A change of length therefore takes effect on the next output, with no flush.
- R6: Before the first enabled edge the output is 0. Any output drawn from a slot never written since power-up is 0.
- R7: The largest length, N = 2^ADDR_W - 1, delays correctly even though its read slot sits right next to the write pointer.
- R8: The write pointer advances by one on each enabled edge and wraps modulo 2^ADDR_W. Delays stay correct after the pointer has wrapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock for the write side and the read side |
| ce | input | 1 | Clock enable; when low the line is frozen |
| din | input | 1 | Serial data in |
| nLen | input | ADDR_W | Programmed delay length in clocks (0 is treated as 1) |
| dout | output | 1 | Serial data out, delayed by the programmed length |

## Verification
The bench uses a 64-entry buffer and sweeps every length from 1 to 63. For each length it checks every cycle against a history of inputs kept in the bench, which catches an off-by-one in the read address: such a design would output the bit one cycle early or late. Length 1 and the largest length are the edges where a design with a wrong read pointer would read the slot being written, or a stale one. Zero length, cycles with the enable low, and a length that changes every cycle are each run. A design that forgot to gate the pointer, or that pipelined the length by a different amount, would show the wrong bit at once. The first outputs after power-up are checked to be 0, and the run goes far past pointer wrap, so a leftover stale bit or a broken modulo would appear.

// File: rtl/dly_pkg.sv
package dly_pkg;

  // Strobes from the control side to the storage side.
  typedef struct packed {
    logic wrEn;    // write the incoming bit into the buffer
    logic rdEn;    // advance the read pipeline
    logic bypass;  // length of one: take the input instead of the buffer
  } dlyStrobe_t;

endpackage

// File: rtl/dly_ctrl.sv
module dly_ctrl
  import dly_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              ce,
  input  logic [ADDR_W-1:0] nLen,
  output dlyStrobe_t        stb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] wrPtr = '0;
  logic [ADDR_W-1:0] nEff;

  // Zero length is folded onto one.
  always_comb nEff = (nLen == '0) ? ONE : nLen;

  // Free-running write pointer; natural wrap at the buffer size.
  always_ff @(posedge clk) begin
    if (ce) wrPtr <= wrPtr + ONE;
  end

  // The read is registered and the output is registered again, so the
  // slot fetched now must be the one written N-1 edges before the next.
  always_comb begin
    wrAddr     = wrPtr;
    rdAddr     = wrPtr - nEff + ONE;
    stb.wrEn   = ce;
    stb.rdEn   = ce;
    stb.bypass = (nEff == ONE);
  end

  logic pastValid = 1'b0;
  always_ff @(posedge clk) pastValid <= 1'b1;

  // R8: pointer steps by one with wrap on every enabled edge
  a_r8_ptr_step: assert property (@(posedge clk) disable iff (!pastValid)
    ce |=> wrAddr == ADDR_W'($past(wrAddr) + ONE));

  // R4: pointer frozen while disabled
  a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!pastValid)
    !ce |=> $stable(wrAddr));

endmodule

// File: rtl/dly_data.sv
module dly_data
  import dly_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  dlyStrobe_t        stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              din,
  output logic              dout
);

  localparam int DEPTH = 1 << ADDR_W;

  logic histBits [DEPTH] = '{default: 1'b0};
  logic rdData = 1'b0;
  logic outQ   = 1'b0;

  // Single-bit buffer, read-before-write on the same edge.
  always_ff @(posedge clk) begin
    if (stb.wrEn) histBits[wrAddr] <= din;
  end

  // First stage: buffer read, or the input itself for a length of one.
  always_ff @(posedge clk) begin
    if (stb.rdEn) rdData <= stb.bypass ? din : histBits[rdAddr];
  end

  // Second stage: output register.
  always_ff @(posedge clk) begin
    if (stb.rdEn) outQ <= rdData;
  end

  assign dout = outQ;

  logic pastValid = 1'b0;
  always_ff @(posedge clk) pastValid <= 1'b1;

  // R4: output holds while the line is frozen
  a_r4_out_hold: assert property (@(posedge clk) disable iff (!pastValid)
    !stb.rdEn |=> $stable(dout));

  // R2: length one captures the live input in the first stage
  a_r2_bypass_take: assert property (@(posedge clk) disable iff (!pastValid)
    (stb.rdEn && stb.bypass) |=> rdData == $past(din));

endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line
  import dly_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              ce,
  input  logic              din,
  input  logic [ADDR_W-1:0] nLen,
  output logic              dout
);

  dlyStrobe_t        stb;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;

  dly_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk    (clk),
    .ce     (ce),
    .nLen   (nLen),
    .stb    (stb),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr)
  );

  dly_data #(.ADDR_W(ADDR_W)) u_data (
    .clk    (clk),
    .stb    (stb),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .din    (din),
    .dout   (dout)
  );

  // R4: no write and no read step while disabled
  a_r4_gate_idle: assert property (@(posedge clk)
    !ce |-> (!stb.wrEn && !stb.rdEn));

  // R3: zero length selects the same bypass as length one
  a_r3_zero_len: assert property (@(posedge clk)
    (nLen == '0) |-> stb.bypass);

endmodule

// File: tb/prog_delay_line_bench.sv
`timescale 1ns/1ps
module prog_delay_line_bench;

  localparam int AW   = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          ce = 1'b0;
  logic          din = 1'b0;
  logic [AW-1:0] nLen = AW'(1);
  logic          dout;

  always #2.5 clk = ~clk;

  prog_delay_line #(.ADDR_W(AW)) u_prog_delay_line (
    .clk  (clk),
    .ce   (ce),
    .din  (din),
    .nLen (nLen),
    .dout (dout)
  );

  int   checks = 0;
  int   errors = 0;
  int   k = 0;
  int   nPrevEff = 1;
  logic expPrev = 1'b0;
  logic hist [0:16383];
  logic [15:0] lf = 16'hACE1;

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dout=%0b expected=%0b (edge %0d)", tag, act, exp, k);
    end
  endtask

  function automatic logic [15:0] lfNext(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // One clock: drive at the falling edge, sample 1 ns after the rising edge.
  task automatic step(input logic b, input logic e, input int n, input string tag);
    logic exp;
    @(negedge clk);
    din  = b;
    ce   = e;
    nLen = AW'(n);
    @(posedge clk);
    #1;
    if (e) begin
      hist[k] = b;
      if (k == 0) exp = 1'b0;
      else if (k - nPrevEff >= 0) exp = hist[k - nPrevEff];
      else exp = 1'b0;
      nPrevEff = (n == 0) ? 1 : n;
      k++;
    end else begin
      exp = expPrev;
    end
    check(dout, exp, tag);
    expPrev = exp;
  endtask

  initial begin
    for (int i = 0; i < 16384; i++) hist[i] = 1'b0;
    #1;
    check(dout, 1'b0, "R6 power-up");

    // R4 disabled edges before any data
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 5, "R4");

    // R6 early outputs are zero, then R1 with random data, N=5
    for (int i = 0; i < 120; i++) begin
      lf = lfNext(lf);
      step(lf[0], 1'b1, 5, (i < 6) ? "R6" : ((k >= DEPTH) ? "R8" : "R1"));
    end

    // R1 alternating and all-ones patterns, N=9
    for (int i = 0; i < 60; i++) step(i[0], 1'b1, 9, "R1");
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 9, "R1");
    // single pulse, N=17
    for (int i = 0; i < 60; i++) step(i == 3, 1'b1, 17, "R1");

    // sweep every legal length
    for (int n = 1; n < DEPTH; n++) begin
      for (int i = 0; i < 80; i++) begin
        string tag;
        lf = lfNext(lf);
        if (i == 0) tag = "R5";
        else if (n == 1) tag = "R2";
        else if (n == DEPTH - 1) tag = "R7";
        else tag = "R1";
        step(lf[3], 1'b1, n, tag);
      end
    end

    // zero length behaves as one
    for (int i = 0; i < 100; i++) begin
      lf = lfNext(lf);
      step(lf[1], 1'b1, 0, "R3");
    end

    // enable toggling, N=7
    for (int i = 0; i < 300; i++) begin
      lf = lfNext(lf);
      step(lf[2], lf[7] | lf[9], 7, "R4");
    end

    // length changes every cycle, including zero
    for (int i = 0; i < 600; i++) begin
      lf = lfNext(lf);
      step(lf[0], 1'b1, int'(lf[11:6]), "R5");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #900000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule